// File: doc/BRIEF.md
# LLR Boxplus / Boxminus Arithmetic Unit

This unit does the pairwise soft-message arithmetic used in an iterative belief-propagation decoder. It works on two's-complement log-likelihood-ratio messages. In boxplus it merges two messages into the message a check node passes on. In boxminus it removes one message from an accumulated boxplus value, so a check node can build one running total and then take each edge's contribution back out.

Both operations start from a sign product and a magnitude taken from a single comparator. A small correction is then added. The correction stands in for the logarithmic terms of the exact rule and is built only from right shifts, constant subtraction and zero clamps; no lookup ROM is used. A min-sum control forces the correction to zero. The arithmetic is combinational, and a single output register retimes the result, so an answer appears one clock after its operands.

Top module: `llr_boxop`

## Requirements
- R1: While rst_ni is low, y_o is 0, whatever the operands and controls are.
- R2: A result appears on y_o at the first rising clock edge after its operands and controls are applied. Until that edge, y_o keeps the previous result.
- R3: Sign rule. A message is negative when its top bit is 1; zero counts as positive. With op_i = 0 (boxplus) and min_sum_i = 1, y_o = s·min(|a_i|,|b_i|), saturated per R8. Here s is -1 when exactly one operand is negative and +1 otherwise.
- R4: With op_i = 0 and min_sum_i = 0, the boxplus result is R3's signed minimum plus g(|a_i+b_i|) − g(|a_i−b_i|), then saturated. Here g(t) = max(0, CORR_C − (t >> CORR_SHIFT)), with CORR_C = 2 and CORR_SHIFT = 2 by default. Sums are formed without overflow.
- R5: With op_i = 1 (boxminus) and |b_i| > |a_i|, the result is s·|a_i| + g(|a_i−b_i|) − g(|a_i+b_i|), then saturated. The correction is forced to 0 when min_sum_i = 1.
- R6: With op_i = 1 and |b_i| ≤ |a_i|, this includes equal magnitudes and both operands zero. y_o is then the most positive code (2^(W−1)−1) when s = +1 and the most negative code (−2^(W−1)) when s = −1, in either min_sum_i setting.
- R7: min_sum_i = 1 removes the correction in both operations.
- R8: Any result above 2^(W−1)−1 becomes 2^(W−1)−1, and any result below −2^(W−1) becomes −2^(W−1). Results never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 1 | 0 = boxplus, 1 = boxminus |
| min_sum_i | input | 1 | 1 = correction forced to zero |
| a_i | input | W | First operand; the accumulated value in boxminus |
| b_i | input | W | Second operand; the message removed in boxminus |
| y_o | output | W | Registered result |

## Verification
Two things can meet in one cycle. The clamp of a degenerate boxminus and the saturation of an over-range corrected value both steer the result to an end of the code range, and a fault in either can hide behind the other. Boxminus pairs with equal magnitudes must clamp. Pairs with |b| just above |a| have a correction that pushes past the most positive code, so they must saturate. The bench also drives the full sweep of every operand pair for both operations and both correction settings, and compares each registered result against an integer model of the requirements.

// File: rtl/llr_pkg.sv
package llr_pkg;
  typedef enum logic {
    OP_PLUS  = 1'b0,
    OP_MINUS = 1'b1
  } box_op_e;
endpackage

// File: rtl/llr_mag.sv
module llr_mag #(
  parameter int W = 4
) (
  input  logic [W-1:0] v_i,
  output logic [W:0]   mag_o,
  output logic         neg_o
);
  logic [W:0] ext;
  assign neg_o = v_i[W-1];
  assign ext   = {v_i[W-1], v_i};
  assign mag_o = neg_o ? (~ext + (W+1)'(1)) : ext;
endmodule

// File: rtl/llr_corr.sv
// g(t) = max(0, C - (|t| >> S)); t is a two's-complement sum of TW bits
module llr_corr #(
  parameter int TW = 5,
  parameter int EW = 8,
  parameter int C  = 2,
  parameter int S  = 2
) (
  input  logic [TW-1:0] t_i,
  output logic [EW-1:0] c_o
);
  localparam logic [EW-1:0] CK = EW'(C);
  logic [TW-1:0] tmag, tsh;
  logic [EW-1:0] tsh_e;
  // |-2^(TW-1)| wraps to 2^(TW-1) read as unsigned: correct
  assign tmag  = t_i[TW-1] ? (~t_i + TW'(1)) : t_i;
  assign tsh   = tmag >> S;
  assign tsh_e = {{(EW-TW){1'b0}}, tsh};
  assign c_o   = (tsh_e >= CK) ? '0 : (CK - tsh_e);
endmodule

// File: rtl/llr_sat.sv
module llr_sat #(
  parameter int W  = 4,
  parameter int EW = 8
) (
  input  logic [EW-1:0] v_i,
  output logic [W-1:0]  y_o
);
  localparam logic signed [EW-1:0] HI = EW'((2**(W-1)) - 1);
  localparam logic signed [EW-1:0] LO = EW'(-(2**(W-1)));
  logic signed [EW-1:0] v;
  logic [EW-1:0] hi_u, lo_u;
  assign v    = signed'(v_i);
  assign hi_u = HI;
  assign lo_u = LO;
  always_comb begin
    if (v > HI)      y_o = hi_u[W-1:0];
    else if (v < LO) y_o = lo_u[W-1:0];
    else             y_o = v_i[W-1:0];
  end
endmodule

// File: rtl/llr_boxop.sv
module llr_boxop
  import llr_pkg::*;
#(
  parameter int W          = 4,
  parameter int CORR_C     = 2,
  parameter int CORR_SHIFT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         op_i,
  input  logic         min_sum_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam int TW = W + 1;
  localparam int EW = W + 4;
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  box_op_e op;
  assign op = box_op_e'(op_i);

  // operand magnitudes and signs
  logic [W:0]   mag [2];
  logic         neg [2];
  logic [W-1:0] opnd [2];
  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar i = 0; i < 2; i++) begin : g_mag
    llr_mag #(.W(W)) u_mag (
      .v_i  (opnd[i]),
      .mag_o(mag[i]),
      .neg_o(neg[i])
    );
  end

  // correction channels: 0 -> a+b, 1 -> a-b
  logic [TW-1:0] a_e, b_e;
  logic [TW-1:0] t   [2];
  logic [EW-1:0] cor [2];
  assign a_e  = {a_i[W-1], a_i};
  assign b_e  = {b_i[W-1], b_i};
  assign t[0] = a_e + b_e;
  assign t[1] = a_e - b_e;

  for (genvar i = 0; i < 2; i++) begin : g_corr
    llr_corr #(.TW(TW), .EW(EW), .C(CORR_C), .S(CORR_SHIFT)) u_corr (
      .t_i(t[i]),
      .c_o(cor[i])
    );
  end

  logic          neg_prod, a_lt_b, clamp;
  logic [W:0]    base_mag;
  logic [EW-1:0] base_e, base_s, corr, pre;
  logic [W-1:0]  sat_y, res_d;

  assign neg_prod = neg[0] ^ neg[1];
  assign a_lt_b   = mag[0] < mag[1];
  // boxminus is defined only while the removed message dominates
  assign clamp    = (op == OP_MINUS) && !a_lt_b;
  assign base_mag = ((op == OP_PLUS) && !a_lt_b) ? mag[1] : mag[0];
  assign base_e   = {{(EW-W-1){1'b0}}, base_mag};
  assign base_s   = neg_prod ? (~base_e + EW'(1)) : base_e;

  always_comb begin
    if (min_sum_i)            corr = '0;
    else if (op == OP_PLUS)   corr = cor[0] - cor[1];
    else                      corr = cor[1] - cor[0];
  end

  assign pre = base_s + corr;

  llr_sat #(.W(W), .EW(EW)) u_sat (
    .v_i(pre),
    .y_o(sat_y)
  );

  assign res_d = clamp ? (neg_prod ? MAX_NEG : MAX_POS) : sat_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_o <= '0;
    else         y_o <= res_d;
  end
endmodule

// File: rtl/llr_boxop_chk.sv
module llr_boxop_chk #(
  parameter int W = 4,
  parameter int C = 2,
  parameter int S = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                op_i,
  input logic                min_sum_i,
  input logic signed [W-1:0] a_i,
  input logic signed [W-1:0] b_i,
  input logic signed [W-1:0] y_o
);
  localparam int MAXP = (2**(W-1)) - 1;
  localparam int MAXN = -(2**(W-1));

  function automatic int mabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int ms_ref(int a, int b);
    int m, r;
    m = (mabs(a) < mabs(b)) ? mabs(a) : mabs(b);
    r = ((a < 0) != (b < 0)) ? -m : m;
    if (r > MAXP) r = MAXP;
    return r;
  endfunction

  AST_MINUS_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i && mabs(int'(b_i)) <= mabs(int'(a_i))) |=>
    (int'(y_o) == ($past(a_i[W-1] ^ b_i[W-1]) ? MAXN : MAXP))); // R6

  AST_MINSUM_PLUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i && min_sum_i) |=>
    (int'(y_o) == ms_ref(int'($past(a_i)), int'($past(b_i))))); // R3

  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i && min_sum_i && (a_i == '0 || b_i == '0)) |=> (y_o == '0)); // R7

  AST_CORR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i && !min_sum_i) |=>
    (mabs(int'(y_o) - ms_ref(int'($past(a_i)), int'($past(b_i)))) <= C)); // R4
endmodule

bind llr_boxop llr_boxop_chk #(.W(W), .C(CORR_C), .S(CORR_SHIFT)) u_chk (.*);

// File: tb/tb_llr_boxop.sv
`timescale 1ns/1ps
module tb_llr_boxop;
  localparam int W    = 4;
  localparam int C    = 2;
  localparam int S    = 2;
  localparam int MAXP = (2**(W-1)) - 1;
  localparam int MAXN = -(2**(W-1));

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         op = 1'b0, ms = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] y;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  llr_boxop #(.W(W), .CORR_C(C), .CORR_SHIFT(S)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .min_sum_i(ms),
    .a_i(a), .b_i(b), .y_o(y)
  );

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int g(int t);
    int r;
    r = C - (iabs(t) >> S);
    return (r < 0) ? 0 : r;
  endfunction

  function automatic int model(int o, int m, int x, int z);
    int ma, mb, base, corr, r;
    bit ng;
    ma = iabs(x); mb = iabs(z);
    ng = (x < 0) != (z < 0);
    if (o == 1 && mb <= ma) return ng ? MAXN : MAXP;
    base = (o == 0) ? ((ma < mb) ? ma : mb) : ma;
    if (ng) base = -base;
    corr = (m != 0) ? 0 : (g(x + z) - g(x - z));
    if (o == 1) corr = -corr;
    r = base + corr;
    if (r > MAXP) r = MAXP;
    if (r < MAXN) r = MAXN;
    return r;
  endfunction

  function automatic int sval(logic [W-1:0] v);
    return int'(signed'(v));
  endfunction

  task automatic check(string tag, int exp);
    checks++;
    if (sval(y) != exp) begin
      errors++;
      $display("FAIL %s op=%0d ms=%0d a=%0d b=%0d got=%0d exp=%0d",
               tag, op, ms, sval(a), sval(b), sval(y), exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic apply(int o, int m, int x, int z, string tag, int exp);
    @(negedge clk);
    op = o[0]; ms = m[0]; a = x[W-1:0]; b = z[W-1:0];
    @(negedge clk);
    check(tag, exp);
  endtask

  function automatic string tag_of(int o, int m, int x, int z);
    if (o == 1 && iabs(z) <= iabs(x)) return "R6";
    if (m == 1) return (o == 0) ? "R3" : "R7";
    return (o == 0) ? "R4" : "R5";
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired got=hang exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1: held in reset with live operands
    op = 1'b0; ms = 1'b1; a = 4'd5; b = 4'd6;
    repeat (3) @(negedge clk);
    check("R1", 0);
    rst_ni = 1'b1;

    // directed values worked from the requirements
    apply(0, 1,  3, -5, "R3", -3);
    apply(0, 1, -8, -8, "R8", 7);
    apply(0, 0,  3,  3, "R4", 2);
    apply(0, 0, -8,  7, "R4", -5);
    apply(1, 0,  2,  5, "R5", 3);
    apply(1, 0,  6,  7, "R8", 7);
    apply(1, 0,  6, -7, "R5", -8);
    apply(1, 0,  4, -4, "R6", -8);
    apply(1, 1,  0,  0, "R6", 7);
    apply(1, 1,  2,  5, "R7", 2);
    apply(0, 1,  3,  3, "R7", 3);

    // R2: new operands are invisible before the next rising edge
    @(negedge clk);
    op = 1'b0; ms = 1'b1; a = 4'd2; b = 4'd6;
    #1 check("R2", 3);
    @(negedge clk);
    check("R2", 2);

    // full sweep of operand pairs, operations and correction settings
    for (int o = 0; o < 2; o++)
      for (int m = 0; m < 2; m++)
        for (int x = MAXN; x <= MAXP; x++)
          for (int z = MAXN; z <= MAXP; z++)
            apply(o, m, x, z, tag_of(o, m, x, z), model(o, m, x, z));

    // R1: reset mid-run clears the register
    @(negedge clk);
    op = 1'b0; ms = 1'b1; a = 4'd7; b = 4'd7;
    rst_ni = 1'b0;
    #1 check("R1", 0);
    @(negedge clk);
    check("R1", 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R2", 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule